// File: doc/BRIEF.md
# Core Memory Cycle Timing Generator

This block sequences one read-restore cycle of a coincident-current core memory with destructive readout. A single-cycle start request, sampled while the block is idle, launches a cycle. From then on a tick counter running on a fast clock (25 ns per tick by default) opens the cycle-enable level, the read-current window, a short sense strobe, the inhibit window and the write-current window, each at a fixed offset from the accepted start. The offsets and widths are parameters given in nanoseconds and converted to ticks.

The block also owns the memory buffer. It clears the buffer when a cycle is accepted and loads the sensed word during the strobe, but only if the strobe-enable input was high at the start. A store-type access therefore keeps the buffer at zero. When the restore half begins, the buffer is ORed with the store word captured at the start and presented as write-back data. A read cycle gives back the word just read. A store cycle with strobe-enable low writes the store word. A store cycle with strobe-enable high writes the OR of both words.

A start request that arrives while a cycle is in flight is dropped and sets a sticky error flag. This rules out the overlapping read and write currents that a second launch would cause.

Top module: `cmt_core_timer`

## Requirements
- R1: After reset every timing output is low, and `busy`, `overlap_err`, `mem_addr`, `mem_buf` and `wb_data` are all zero.
- R2: A `mem_start` sampled high while idle raises `mem_enable` and `busy` from the next cycle. Both stay high for exactly CYCLE_NS/TICK_NS ticks (140 by default).
- R3: `mem_read` is high for the first READ_NS/TICK_NS ticks of the cycle (28), beginning in the same tick as `mem_enable`.
- R4: `sense_strobe` is high for STROBE_NS/TICK_NS ticks (4). It starts STROBE_AT_NS/TICK_NS ticks (12) after the edge that accepted the start.
- R5: `mem_inhibit` is high for INHIBIT_NS/TICK_NS ticks (20), starting at tick INHIBIT_AT_NS/TICK_NS (100) of the cycle.
- R6: `mem_write` rises WRITE_LAG_NS/TICK_NS ticks (3) after `mem_inhibit` rises and stays high for WRITE_NS/TICK_NS ticks (16). It is never high together with `mem_read` and is always inside the inhibit window.
- R7: An accepted start clears `mem_buf`. If `strobe_en` was high at the start, `mem_buf` holds `sense_data` once the strobe ends. If it was low, `mem_buf` stays zero.
- R8: From the first inhibit tick to the end of the cycle, `wb_data` and `mem_buf` both equal the strobed buffer value ORed with the `store_data` captured at the start.
- R9: A `mem_start` sampled high while `busy` is high leaves the cycle's timing unchanged and sets `overlap_err` from the next cycle. The flag stays set until reset. This holds also on the last tick of a cycle.
- R10: A `mem_start` on the first idle cycle after `mem_enable` falls is accepted, so cycles can run back to back.
- R11: `mem_addr` takes `addr_in` at the accepting edge and holds it for the whole cycle, whatever `addr_in` does meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_start | input | 1 | Cycle launch request, sampled each tick |
| strobe_en | input | 1 | Allows sensed data into the buffer; captured at the start |
| addr_in | input | ADDR_W | Word address, captured at the start |
| store_data | input | WORD_W | Word ORed into the buffer at restore; captured at the start |
| sense_data | input | WORD_W | Sense-amplifier output word |
| mem_enable | output | 1 | Cycle-enable level |
| mem_read | output | 1 | Read-current window |
| sense_strobe | output | 1 | Sense strobe pulse |
| mem_inhibit | output | 1 | Inhibit window |
| mem_write | output | 1 | Write-current window |
| busy | output | 1 | Cycle in progress |
| overlap_err | output | 1 | Sticky flag for a start received while busy |
| mem_addr | output | ADDR_W | Address held for the cycle |
| mem_buf | output | WORD_W | Memory buffer |
| wb_data | output | WORD_W | Write-back word for the restore half |

## Verification
The bench uses the default parameters: a 25 ns tick, 12-bit address and 12-bit word. Every window therefore appears at its real offset, from tick 0 through tick 139, and each output is compared on every tick of every cycle. Because the cycle is only 140 ticks long, the bench can run many complete cycles back to back. It can also inject a start in the middle of a cycle and on the very last busy tick, and test read, clean store and OR-corrupted store against a small modelled core array.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Timing levels produced for one tick of a core cycle.
    typedef struct packed {
        logic en;
        logic rd;
        logic stb;
        logic inh;
        logic wr;
    } win_t;

    // Number of ranged windows decoded from the tick count (rd, stb, inh, wr).
    localparam int NUM_WIN = 4;

endpackage

// File: rtl/cmt_phase_counter.sv
module cmt_phase_counter #(
    parameter int EN_LEN = 140,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             accept_o,
    output logic             overlap_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(EN_LEN - 1);

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ctr_q.busy) begin
            if (ctr_q.cnt == LAST) begin
                ctr_d.busy = 1'b0;
                ctr_d.cnt  = '0;
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            ctr_d.busy = 1'b1;
            ctr_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign busy_o    = ctr_q.busy;
    assign cnt_o     = ctr_q.cnt;
    assign accept_o  = start_i && !ctr_q.busy;
    assign overlap_o = start_i && ctr_q.busy;

endmodule

// File: rtl/cmt_window_decode.sv
module cmt_window_decode #(
    parameter int CNT_W   = 8,
    parameter int RD_LEN  = 28,
    parameter int STB_OFS = 12,
    parameter int STB_LEN = 4,
    parameter int INH_OFS = 100,
    parameter int INH_LEN = 20,
    parameter int WR_DLY  = 3,
    parameter int WR_LEN  = 16
) (
    input  logic               busy_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output cmt_pkg::win_t      win_o,
    output logic               restore_o
);

    localparam int NW = cmt_pkg::NUM_WIN;
    // Window bounds, [LO, HI) in ticks: read, strobe, inhibit, write.
    localparam int LO [NW] = '{0, STB_OFS, INH_OFS, INH_OFS + WR_DLY};
    localparam int HI [NW] = '{RD_LEN, STB_OFS + STB_LEN,
                               INH_OFS + INH_LEN, INH_OFS + WR_DLY + WR_LEN};

    int            cnt_int;
    logic [NW-1:0] hit;

    assign cnt_int = {{(32-CNT_W){1'b0}}, cnt_i};

    for (genvar i = 0; i < NW; i++) begin : g_win
        assign hit[i] = busy_i && (cnt_int >= LO[i]) && (cnt_int < HI[i]);
    end

    always_comb begin
        win_o.en  = busy_i;
        win_o.rd  = hit[0];
        win_o.stb = hit[1];
        win_o.inh = hit[2];
        win_o.wr  = hit[3];
    end

    // Last tick before the restore half opens.
    assign restore_o = busy_i && (cnt_int == INH_OFS - 1);

endmodule

// File: rtl/cmt_buffer.sv
module cmt_buffer #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              strobe_en_i,
    input  logic [WORD_W-1:0] store_i,
    input  logic [WORD_W-1:0] sense_i,
    input  logic              strobe_i,
    input  logic              restore_i,
    output logic [WORD_W-1:0] mb_o,
    output logic [WORD_W-1:0] wb_o
);

    typedef struct packed {
        logic              sten;
        logic [WORD_W-1:0] store;
        logic [WORD_W-1:0] mb;
        logic [WORD_W-1:0] wb;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (accept_i) begin
            buf_d.sten  = strobe_en_i;
            buf_d.store = store_i;
            buf_d.mb    = '0;
            buf_d.wb    = '0;
        end else if (strobe_i && buf_q.sten) begin
            buf_d.mb = sense_i;
        end else if (restore_i) begin
            buf_d.mb = buf_q.mb | buf_q.store;
            buf_d.wb = buf_q.mb | buf_q.store;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign mb_o = buf_q.mb;
    assign wb_o = buf_q.wb;

endmodule

// File: rtl/cmt_core_timer.sv
module cmt_core_timer #(
    parameter int ADDR_W        = 12,
    parameter int WORD_W        = 12,
    parameter int TICK_NS       = 25,
    parameter int CYCLE_NS      = 3500,
    parameter int READ_NS       = 700,
    parameter int STROBE_AT_NS  = 300,
    parameter int STROBE_NS     = 100,
    parameter int INHIBIT_AT_NS = 2500,
    parameter int INHIBIT_NS    = 500,
    parameter int WRITE_LAG_NS  = 75,
    parameter int WRITE_NS      = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_start,
    input  logic              strobe_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] store_data,
    input  logic [WORD_W-1:0] sense_data,
    output logic              mem_enable,
    output logic              mem_read,
    output logic              sense_strobe,
    output logic              mem_inhibit,
    output logic              mem_write,
    output logic              busy,
    output logic              overlap_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_buf,
    output logic [WORD_W-1:0] wb_data
);

    localparam int EN_LEN  = CYCLE_NS / TICK_NS;
    localparam int RD_LEN  = READ_NS / TICK_NS;
    localparam int STB_OFS = STROBE_AT_NS / TICK_NS;
    localparam int STB_LEN = STROBE_NS / TICK_NS;
    localparam int INH_OFS = INHIBIT_AT_NS / TICK_NS;
    localparam int INH_LEN = INHIBIT_NS / TICK_NS;
    localparam int WR_DLY  = WRITE_LAG_NS / TICK_NS;
    localparam int WR_LEN  = WRITE_NS / TICK_NS;
    localparam int CNT_W   = $clog2(EN_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              err;
    } top_t;

    top_t              top_d, top_q;
    logic              busy_w, accept_w, overlap_w, restore_w;
    logic [CNT_W-1:0]  cnt_w;
    cmt_pkg::win_t     win_w;

    cmt_phase_counter #(
        .EN_LEN (EN_LEN),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (mem_start),
        .busy_o    (busy_w),
        .cnt_o     (cnt_w),
        .accept_o  (accept_w),
        .overlap_o (overlap_w)
    );

    cmt_window_decode #(
        .CNT_W   (CNT_W),
        .RD_LEN  (RD_LEN),
        .STB_OFS (STB_OFS),
        .STB_LEN (STB_LEN),
        .INH_OFS (INH_OFS),
        .INH_LEN (INH_LEN),
        .WR_DLY  (WR_DLY),
        .WR_LEN  (WR_LEN)
    ) u_dec (
        .busy_i    (busy_w),
        .cnt_i     (cnt_w),
        .win_o     (win_w),
        .restore_o (restore_w)
    );

    cmt_buffer #(
        .WORD_W (WORD_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept_w),
        .strobe_en_i (strobe_en),
        .store_i     (store_data),
        .sense_i     (sense_data),
        .strobe_i    (win_w.stb),
        .restore_i   (restore_w),
        .mb_o        (mem_buf),
        .wb_o        (wb_data)
    );

    always_comb begin
        top_d = top_q;
        if (accept_w) begin
            top_d.addr = addr_in;
        end
        if (overlap_w) begin
            top_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign mem_enable   = win_w.en;
    assign mem_read     = win_w.rd;
    assign sense_strobe = win_w.stb;
    assign mem_inhibit  = win_w.inh;
    assign mem_write    = win_w.wr;
    assign busy         = busy_w;
    assign overlap_err  = top_q.err;
    assign mem_addr     = top_q.addr;

endmodule

// File: rtl/cmt_core_timer_chk.sv
module cmt_core_timer_chk #(
    parameter int ADDR_W  = 12,
    parameter int EN_LEN  = 140,
    parameter int STB_OFS = 12,
    parameter int STB_LEN = 4,
    parameter int INH_OFS = 100,
    parameter int INH_LEN = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_start,
    input logic              mem_enable,
    input logic              mem_read,
    input logic              sense_strobe,
    input logic              mem_inhibit,
    input logic              mem_write,
    input logic              busy,
    input logic              overlap_err,
    input logic [ADDR_W-1:0] mem_addr
);

    // Ticks the enable level has been high so far (independent of the design counter).
    int hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= 0;
        end else if (mem_enable) begin
            hi_cnt_q <= hi_cnt_q + 1;
        end else begin
            hi_cnt_q <= 0;
        end
    end

    // R2
    enable_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_enable) |-> hi_cnt_q == EN_LEN);

    // R2
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == mem_enable);

    // R3
    read_in_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> mem_enable);

    // R3
    read_at_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_enable) |-> mem_read);

    // R4
    strobe_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_strobe |-> (hi_cnt_q >= STB_OFS && hi_cnt_q < STB_OFS + STB_LEN));

    // R5
    inhibit_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> (hi_cnt_q >= INH_OFS && hi_cnt_q < INH_OFS + INH_LEN));

    // R6
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read && mem_write));

    // R6
    write_in_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> mem_inhibit);

    // R9
    err_on_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_start && busy) |=> overlap_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

bind cmt_core_timer cmt_core_timer_chk #(
    .ADDR_W  (ADDR_W),
    .EN_LEN  (EN_LEN),
    .STB_OFS (STB_OFS),
    .STB_LEN (STB_LEN),
    .INH_OFS (INH_OFS),
    .INH_LEN (INH_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_start    (mem_start),
    .mem_enable   (mem_enable),
    .mem_read     (mem_read),
    .sense_strobe (sense_strobe),
    .mem_inhibit  (mem_inhibit),
    .mem_write    (mem_write),
    .busy         (busy),
    .overlap_err  (overlap_err),
    .mem_addr     (mem_addr)
);

// File: tb/tb_cmt_core_timer.sv
module tb_cmt_core_timer;

    // Tick values from the requirements at default parameters.
    localparam int T_EN   = 140;
    localparam int T_RD   = 28;
    localparam int T_SOFS = 12;
    localparam int T_SLEN = 4;
    localparam int T_IOFS = 100;
    localparam int T_ILEN = 20;
    localparam int T_WDLY = 3;
    localparam int T_WLEN = 16;
    localparam int NMEM   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_start = 1'b0;
    logic        strobe_en = 1'b0;
    logic [11:0] addr_in = '0;
    logic [11:0] store_data = '0;
    logic [11:0] sense_data;
    logic        mem_enable, mem_read, sense_strobe, mem_inhibit, mem_write;
    logic        busy, overlap_err;
    logic [11:0] mem_addr, mem_buf, wb_data;

    logic [11:0] core [NMEM];
    logic [11:0] exp_mem [NMEM];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  err_exp = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    cmt_core_timer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_start    (mem_start),
        .strobe_en    (strobe_en),
        .addr_in      (addr_in),
        .store_data   (store_data),
        .sense_data   (sense_data),
        .mem_enable   (mem_enable),
        .mem_read     (mem_read),
        .sense_strobe (sense_strobe),
        .mem_inhibit  (mem_inhibit),
        .mem_write    (mem_write),
        .busy         (busy),
        .overlap_err  (overlap_err),
        .mem_addr     (mem_addr),
        .mem_buf      (mem_buf),
        .wb_data      (wb_data)
    );

    // Simple core array model: sense reads the held address, write stores wb_data.
    assign sense_data = core[mem_addr[5:0]];
    always @(posedge clk) begin
        if (mem_write) core[mem_addr[5:0]] <= wb_data;
    end

    // Vectors: {strobe_en, addr, store word}
    localparam int NVEC = 8;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 12'h005, 12'h000},   // read
        {1'b0, 12'h005, 12'hAAA},   // clean store
        {1'b1, 12'h005, 12'h000},   // read back
        {1'b0, 12'hFFF, 12'h123},   // store at top address
        {1'b1, 12'hFFF, 12'h000},   // read back
        {1'b1, 12'h005, 12'h0F0},   // store with strobe left on: OR
        {1'b1, 12'h005, 12'h000},   // read back
        {1'b1, 12'h03A, 12'h000}    // read untouched word
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Entered at a negedge with the block idle; returns at a negedge with it idle.
    task automatic run_cycle(input logic sten, input logic [11:0] a,
                             input logic [11:0] st, input int inj);
        logic [11:0] mb_exp, wb_exp;
        int idx;
        idx = int'(a[5:0]);
        mb_exp = sten ? exp_mem[idx] : 12'h000;
        wb_exp = mb_exp | st;
        mem_start  = 1'b1;
        strobe_en  = sten;
        addr_in    = a;
        store_data = st;
        @(negedge clk);
        for (int k = 0; k <= T_EN; k++) begin
            mem_start = (k == inj);
            if (k == 5) begin
                addr_in    = ~a;
                store_data = ~st;
                strobe_en  = ~sten;
            end
            chk("R2 mem_enable", 32'(mem_enable), 32'(k < T_EN));
            chk("R2 busy", 32'(busy), 32'(k < T_EN));
            chk("R3 mem_read", 32'(mem_read), 32'(k < T_RD));
            chk("R4 sense_strobe", 32'(sense_strobe), 32'(k >= T_SOFS && k < T_SOFS + T_SLEN));
            chk("R5 mem_inhibit", 32'(mem_inhibit), 32'(k >= T_IOFS && k < T_IOFS + T_ILEN));
            chk("R6 mem_write", 32'(mem_write),
                32'(k >= T_IOFS + T_WDLY && k < T_IOFS + T_WDLY + T_WLEN));
            chk("R9 overlap_err", 32'(overlap_err), 32'(err_exp || (inj >= 0 && k > inj)));
            if (k < T_EN) chk("R11 mem_addr", 32'(mem_addr), 32'(a));
            if (k == 0) chk("R7 mem_buf cleared", 32'(mem_buf), 32'h0);
            if (k == T_SOFS + T_SLEN) chk("R7 mem_buf after strobe", 32'(mem_buf), 32'(mb_exp));
            if (k == T_IOFS || k == T_EN - 1) begin
                chk("R8 wb_data", 32'(wb_data), 32'(wb_exp));
                chk("R8 mem_buf restore", 32'(mem_buf), 32'(wb_exp));
            end
            if (k < T_EN) @(negedge clk);
        end
        if (inj >= 0) err_exp = 1'b1;
        exp_mem[idx] = wb_exp;
    endtask

    initial begin
        for (int i = 0; i < NMEM; i++) begin
            core[i]    = 12'(i * 73 + 5);
            exp_mem[i] = 12'(i * 73 + 5);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mem_enable", 32'(mem_enable), 32'h0);
        chk("R1 timing", 32'({mem_read, sense_strobe, mem_inhibit, mem_write}), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 overlap_err", 32'(overlap_err), 32'h0);
        chk("R1 regs", 32'({mem_addr, mem_buf}), 32'h0);
        chk("R1 wb_data", 32'(wb_data), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(busy), 32'h0);

        // Table walk; every entry starts on the first idle cycle (R10).
        for (int v = 0; v < NVEC; v++) begin
            run_cycle(VEC[v][24], VEC[v][23:12], VEC[v][11:0], -1);
        end

        // R9: start mid-cycle is dropped, flag set; next start back to back (R10)
        run_cycle(1'b1, 12'h011, 12'h000, 60);
        run_cycle(1'b1, 12'h012, 12'h000, -1);
        // R9: start on the last busy tick is dropped too
        run_cycle(1'b0, 12'h013, 12'h555, T_EN - 1);
        chk("R9 no launch after last-tick start", 32'(busy), 32'h0);
        @(negedge clk);
        chk("R9 still idle", 32'(mem_enable), 32'h0);
        chk("R9 flag held", 32'(overlap_err), 32'h1);

        // R9 / R1: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        err_exp = 1'b0;
        @(negedge clk);
        chk("R9 flag cleared by reset", 32'(overlap_err), 32'h0);
        run_cycle(1'b1, 12'h013, 12'h000, -1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule